// File: doc/BRIEF.md
# Page Replacement Engine with Selectable Victim Policy

This block models a small set of physical frames, each holding one page number. It takes page references one at a time over a valid/ready handshake. For every accepted reference it reports one of two outcomes. On a hit it returns the frame that already holds the page. On a fault it returns the frame into which the page was loaded, together with the page it displaced, if any. It also keeps a running count of faults.

Empty frames are used first. Once every frame is occupied, a two-bit policy input chooses the victim. Four policies are available: the page loaded earliest, the page referenced least recently, the page with the smallest reference count, or the page with the largest reference count. A synchronous clear empties the frames and zeroes the fault count. Changing the policy also empties the frames, so each policy starts from a clean state.

Top module: `page_swap_engine`

## Requirements
- R1: When the frames are not all occupied, a reference to a page that is not resident is a fault. It is placed in the lowest-numbered empty frame and reports no eviction.
- R2: A reference to a resident page reports hit (res_hit=1). It returns that page's frame, evicts nothing (res_evict_valid=0) and leaves the fault count unchanged.
- R3: With pol_sel=0 (oldest-loaded), a fault into full frames evicts the page that was loaded earliest, regardless of how recently it was referenced.
- R4: With pol_sel=1 (least-recent), a fault into full frames evicts the page whose most recent reference is the oldest. Both loads and hits count as references.
- R5: With pol_sel=2 (least-count), a fault into full frames evicts the page with the smallest reference count. A page's count is 1 when it is loaded and rises by 1 on each hit.
- R6: With pol_sel=3 (most-count), a fault into full frames evicts the page with the largest reference count. Counts follow the same rule as in R5.
- R7: When several frames tie for victim, the lowest-numbered of them is chosen.
- R8: A result (res_valid=1 for one cycle) appears in the cycle after a reference is accepted. No result appears in any other cycle.
- R9: fault_count rises by one per fault and saturates at its all-ones value.
- R10: While clr is high, ref_ready is 0. After a clear, fault_count is 0 and all frames are empty.
- R11: When pol_sel differs from the policy currently in force, ref_ready is 0 for one cycle. The new policy then takes effect with all frames empty, and fault_count is kept.
- R12: After reset, ref_ready is 1 (with pol_sel=0 and clr=0), res_valid is 0 and fault_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of frames and fault count |
| pol_sel | input | 2 | Victim policy: 0 oldest-loaded, 1 least-recent, 2 least-count, 3 most-count |
| ref_valid | input | 1 | Reference request |
| ref_ready | output | 1 | Engine can accept a reference |
| ref_page | input | PAGE_W | Referenced page number |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | 1 for hit, 0 for fault |
| res_frame | output | IDX_W | Frame hit or loaded |
| res_evict_valid | output | 1 | A resident page was displaced |
| res_evict_page | output | PAGE_W | Displaced page number |
| fault_count | output | FAULT_W | Saturating fault counter |

## Verification
The hardest situations to reach are the tie cases for victim selection: two frames with equal reference counts in least-count and most-count mode. The stimulus creates them on purpose. It first raises one page's count with repeated hits, then lets an eviction replace a single page so that several count-1 frames remain. Least-recent mode is checked with a sequence in which a hit changes the recency order, so that its victim differs from the oldest-loaded victim for the same sequence. The bench uses three frames and a three-bit fault counter, so saturation is reached within ten references.

// File: rtl/pse_pkg.sv
// Package: shared policy encoding for the page replacement engine.
// Assumes the policy select is a two-bit field whose codes are fixed by the port contract.
package pse_pkg;
    typedef enum logic [1:0] {
        POL_OLDEST   = 2'd0,
        POL_RECENT   = 2'd1,
        POL_LEASTCNT = 2'd2,
        POL_MOSTCNT  = 2'd3
    } policy_e;
endpackage

// File: rtl/pse_lookup.sv
// Module: pse_lookup
// Searches the frame table for the referenced page and finds the lowest empty frame.
// Assumes at most one valid frame holds any given page (the owner keeps pages unique).
module pse_lookup #(
    parameter int NUM_FRAMES = 8,
    parameter int PAGE_W     = 16,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic [NUM_FRAMES-1:0]             frm_valid,
    input  logic [NUM_FRAMES-1:0][PAGE_W-1:0] frm_page,
    input  logic [PAGE_W-1:0]                 look_page,
    output logic [NUM_FRAMES-1:0]             match_vec,
    output logic                              is_hit,
    output logic [IDX_W-1:0]                  hit_idx,
    output logic                              all_full,
    output logic [IDX_W-1:0]                  free_idx
);
    // per-frame comparators
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
        assign match_vec[g] = frm_valid[g] && (frm_page[g] == look_page);
    end

    // encode the matching frame index
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    // lowest-numbered empty frame
    always_comb begin
        free_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (!frm_valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign is_hit   = |match_vec;
    assign all_full = &frm_valid;
endmodule

// File: rtl/pse_victim_select.sv
// Module: pse_victim_select
// Picks the frame to evict when all frames are occupied, per the active policy.
// Assumes all frames are valid when the result is used; ties go to the lowest index.
module pse_victim_select
    import pse_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int CNT_W      = 8,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  policy_e                          policy,
    input  logic [NUM_FRAMES-1:0][CNT_W-1:0] frm_cnt,
    input  logic [NUM_FRAMES-1:0][IDX_W-1:0] frm_rank,
    input  logic [IDX_W-1:0]                 oldest_ptr,
    output logic [IDX_W-1:0]                 victim_idx
);
    logic [IDX_W-1:0] best;

    // scan frames, replacing the best only on a strict improvement
    always_comb begin
        best = '0;
        for (int i = 1; i < NUM_FRAMES; i++) begin
            unique case (policy)
                POL_RECENT:   if (frm_rank[i] > frm_rank[best]) best = IDX_W'(i);
                POL_LEASTCNT: if (frm_cnt[i]  < frm_cnt[best])  best = IDX_W'(i);
                POL_MOSTCNT:  if (frm_cnt[i]  > frm_cnt[best])  best = IDX_W'(i);
                default:      best = best;
            endcase
        end
    end

    // oldest-loaded uses the round-robin load pointer
    assign victim_idx = (policy == POL_OLDEST) ? oldest_ptr : best;
endmodule

// File: rtl/pse_sat_counter.sv
// Module: pse_sat_counter
// Saturating event counter with synchronous clear.
// Assumes at most one increment per cycle.
module pse_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // count up, hold at the top value
    always_ff @(posedge clk) begin
        if (!rst_n || clr)               count <= '0;
        else if (inc && (count != MAXV)) count <= count + 1'b1;
    end

    AST_FAULT_HOLD_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV) && !clr |=> (count == MAXV)); // R9
    AST_FAULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !clr && (count != MAXV) |=> (count == $past(count) + 1'b1)); // R9
endmodule

// File: rtl/page_swap_engine.sv
// Module: page_swap_engine
// Frame table with hit/fault handling, four victim policies and a fault counter.
// Assumes one reference per accepted handshake; a result follows one cycle later.
// Frames are emptied by clr or by a change of pol_sel.
module page_swap_engine
    import pse_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int PAGE_W     = 16,
    parameter int CNT_W      = 8,
    parameter int FAULT_W    = 16,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [1:0]         pol_sel,
    input  logic               ref_valid,
    output logic               ref_ready,
    input  logic [PAGE_W-1:0]  ref_page,
    output logic               res_valid,
    output logic               res_hit,
    output logic [IDX_W-1:0]   res_frame,
    output logic               res_evict_valid,
    output logic [PAGE_W-1:0]  res_evict_page,
    output logic [FAULT_W-1:0] fault_count
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [IDX_W-1:0] RANK_TOP = IDX_W'(NUM_FRAMES - 1);

    policy_e                          mode_q;
    logic [NUM_FRAMES-1:0]            valid_q;
    logic [NUM_FRAMES-1:0][PAGE_W-1:0] page_q;
    logic [NUM_FRAMES-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_FRAMES-1:0][IDX_W-1:0] rank_q;
    logic [IDX_W-1:0]                 oldest_q;

    logic [NUM_FRAMES-1:0] match_vec;
    logic                  is_hit, all_full;
    logic [IDX_W-1:0]      hit_idx, free_idx, victim_idx, tgt_idx;
    logic [IDX_W-1:0]      ref_rank;
    logic                  accept, evict, mode_chg;

    pse_lookup #(.NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W)) u_lookup (
        .frm_valid (valid_q),
        .frm_page  (page_q),
        .look_page (ref_page),
        .match_vec (match_vec),
        .is_hit    (is_hit),
        .hit_idx   (hit_idx),
        .all_full  (all_full),
        .free_idx  (free_idx)
    );

    pse_victim_select #(.NUM_FRAMES(NUM_FRAMES), .CNT_W(CNT_W)) u_victim (
        .policy     (mode_q),
        .frm_cnt    (cnt_q),
        .frm_rank   (rank_q),
        .oldest_ptr (oldest_q),
        .victim_idx (victim_idx)
    );

    pse_sat_counter #(.W(FAULT_W)) u_faults (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (accept && !is_hit),
        .count (fault_count)
    );

    // handshake and target frame selection
    always_comb begin
        mode_chg  = (policy_e'(pol_sel) != mode_q);
        ref_ready = !clr && !mode_chg;
        accept    = ref_valid && ref_ready;
        evict     = !is_hit && all_full;
        tgt_idx   = is_hit ? hit_idx : (all_full ? victim_idx : free_idx);
        ref_rank  = (is_hit || all_full) ? rank_q[tgt_idx] : RANK_TOP;
    end

    // frame table, policy state and recency ranks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= POL_OLDEST;
            valid_q  <= '0;
            oldest_q <= '0;
        end else if (clr || mode_chg) begin
            mode_q   <= policy_e'(pol_sel);
            valid_q  <= '0;
            oldest_q <= '0;
        end else if (accept) begin
            for (int i = 0; i < NUM_FRAMES; i++) begin
                if (IDX_W'(i) == tgt_idx) begin
                    valid_q[i] <= 1'b1;
                    page_q[i]  <= ref_page;
                    rank_q[i]  <= '0;
                    if (!is_hit)                cnt_q[i] <= CNT_W'(1);
                    else if (cnt_q[i] != CNT_MAX) cnt_q[i] <= cnt_q[i] + 1'b1;
                end else if (valid_q[i] && (rank_q[i] < ref_rank)) begin
                    rank_q[i] <= rank_q[i] + 1'b1;
                end
            end
            if (evict && (mode_q == POL_OLDEST))
                oldest_q <= (oldest_q == RANK_TOP) ? '0 : oldest_q + 1'b1;
        end
    end

    // result register, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            res_valid       <= 1'b0;
            res_hit         <= 1'b0;
            res_frame       <= '0;
            res_evict_valid <= 1'b0;
            res_evict_page  <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_hit         <= is_hit;
                res_frame       <= tgt_idx;
                res_evict_valid <= evict;
                res_evict_page  <= evict ? page_q[tgt_idx] : '0;
            end
        end
    end

    AST_UNIQUE_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R2
    AST_HIT_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_hit |-> !res_evict_valid); // R2
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !clr |=> res_valid); // R8
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !res_valid); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid_q == '0)); // R10
    AST_FILL_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !all_full |=> !res_evict_valid); // R1
endmodule

// File: tb/page_swap_engine_tb.sv
module page_swap_engine_tb;
    localparam int NF = 3, PW = 8, CW = 4, FW = 3, IW = 2;

    logic          clk = 1'b0, rst_n = 1'b0, clr = 1'b0, ref_valid = 1'b0;
    logic [1:0]    pol_sel = 2'd0;
    logic [PW-1:0] ref_page = '0;
    logic          ref_ready, res_valid, res_hit, res_evict_valid;
    logic [IW-1:0] res_frame;
    logic [PW-1:0] res_evict_page;
    logic [FW-1:0] fault_count;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    page_swap_engine #(.NUM_FRAMES(NF), .PAGE_W(PW), .CNT_W(CW), .FAULT_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pol_sel(pol_sel),
        .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_page(ref_page),
        .res_valid(res_valid), .res_hit(res_hit), .res_frame(res_frame),
        .res_evict_valid(res_evict_valid), .res_evict_page(res_evict_page),
        .fault_count(fault_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one reference; result checked at the next falling edge
    task automatic do_ref(input string req, input int pg, input bit hit,
                          input int frm, input bit ev, input int evpg);
        @(negedge clk);
        ref_page = PW'(pg); ref_valid = 1'b1;
        @(negedge clk);
        ref_valid = 1'b0;
        chk({req, " res_valid"}, res_valid, 1);
        chk({req, " hit"}, res_hit, hit);
        chk({req, " frame"}, res_frame, frm);
        chk({req, " evict_valid"}, res_evict_valid, ev);
        if (ev) chk({req, " evict_page"}, res_evict_page, evpg);
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        #1 chk("R10 ready low in clear", ref_ready, 0);
        @(negedge clk); clr = 1'b0;
        chk("R10 count zero after clear", fault_count, 0);
    endtask

    task automatic set_mode(input int m);
        @(negedge clk); pol_sel = 2'(m);
        #1 chk("R11 ready low on policy change", ref_ready, 0);
        @(negedge clk);
        chk("R11 ready back after change", ref_ready, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12 ready", ref_ready, 1);
        chk("R12 res_valid", res_valid, 0);
        chk("R12 fault_count", fault_count, 0);
    endtask

    task automatic t_oldest();
        do_clear();
        do_ref("R1 fill f0", 6, 0, 0, 0, 0);
        do_ref("R1 fill f1", 0, 0, 1, 0, 0);
        do_ref("R1 fill f2", 1, 0, 2, 0, 0);
        do_ref("R3 evict 6", 2, 0, 0, 1, 6);
        do_ref("R2 hit 0", 0, 1, 1, 0, 0);
        chk("R2 hit keeps count", fault_count, 4);
        do_ref("R3 evict 0 despite recent use", 3, 0, 1, 1, 0);
        @(negedge clk);
        chk("R8 no result when idle", res_valid, 0);
        chk("R9 count five", fault_count, 5);
    endtask

    task automatic t_recent();
        set_mode(1);
        do_clear();
        do_ref("R1 fill f0", 7, 0, 0, 0, 0);
        do_ref("R1 fill f1", 0, 0, 1, 0, 0);
        do_ref("R1 fill f2", 1, 0, 2, 0, 0);
        do_ref("R4 evict 7", 2, 0, 0, 1, 7);
        do_ref("R2 hit 0", 0, 1, 1, 0, 0);
        do_ref("R4 evict 1", 3, 0, 2, 1, 1);
    endtask

    task automatic t_leastcnt();
        set_mode(2);
        do_clear();
        do_ref("R5 load 5", 5, 0, 0, 0, 0);
        do_ref("R5 hit 5", 5, 1, 0, 0, 0);
        do_ref("R5 hit 5 again", 5, 1, 0, 0, 0);
        do_ref("R1 fill 6", 6, 0, 1, 0, 0);
        do_ref("R1 fill 7", 7, 0, 2, 0, 0);
        do_ref("R7 tie evicts lower frame", 8, 0, 1, 1, 6);
        do_ref("R5 evict count-1 page", 6, 0, 1, 1, 8);
    endtask

    task automatic t_policy_change();
        set_mode(3);
        do_ref("R11 frames empty after change", 5, 0, 0, 0, 0);
    endtask

    task automatic t_mostcnt();
        do_clear();
        do_ref("R1 fill 5", 5, 0, 0, 0, 0);
        do_ref("R1 fill 6", 6, 0, 1, 0, 0);
        do_ref("R6 hit 6", 6, 1, 1, 0, 0);
        do_ref("R1 fill 7", 7, 0, 2, 0, 0);
        do_ref("R6 evict highest count", 8, 0, 1, 1, 6);
        do_ref("R7 all tie evicts f0", 9, 0, 0, 1, 5);
    endtask

    task automatic t_saturate();
        set_mode(0);
        do_clear();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); ref_page = PW'(20 + i); ref_valid = 1'b1;
        end
        @(negedge clk); ref_valid = 1'b0;
        chk("R9 saturated", fault_count, 7);
    endtask

    task automatic t_clear();
        do_ref("R2 hit before clear", 29, 1, 0, 0, 0);
        do_clear();
        do_ref("R10 frames empty after clear", 29, 0, 0, 0, 0);
        chk("R10 count restarts", fault_count, 1);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_oldest();
        t_recent();
        t_leastcnt();
        t_policy_change();
        t_mostcnt();
        t_saturate();
        t_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule